// File: doc/BRIEF.md
# Descriptor Command List Sequencer

This block executes a chain of 16-byte command descriptors that software has placed in memory. Starting at a loaded command pointer, it reads a descriptor as four 32-bit little-endian words and decodes it. It then starts a stream transfer, performs a single-word memory access, does nothing, or halts. After the work completes it records the channel status and the residual byte count back into that same descriptor, and moves to the following descriptor or jumps to a target address taken from the descriptor.

Each descriptor carries three 2-bit control fields: wait, interrupt and branch. Each field picks never, when the condition is true, when the condition is false, or always. The three condition bits come from an external masked-compare unit as the inputs `waitCond`, `intrCond` and `branchCond`. The sequencer only combines them with the fields. Illegal descriptors kill the channel, which marks it dead and raises an interrupt.

The channel is started by a rising `runIn` or by a `wakeIn` pulse. It keeps walking the list while run and active both hold.

Top module: `dseq_top`

## Requirements
- R1: After reset the command pointer is 0, the flag bits of `statusWord` (bits 15:8 except run, which follows `runIn`) are 0, and neither `memReq` nor `xferReq` is asserted.
- R2: A descriptor at pointer P is read as four words at P, P+4, P+8 and P+12. Word 0 holds the request count in bits 15:0 and the command word in bits 31:16. Word 1 is the data address, word 2 the dependent word, and word 3 holds the residual in bits 15:0 and the status in bits 31:16. Command word fields are: opcode 15:12, key 10:8, interrupt 5:4, branch 3:2, wait 1:0.
- R3: Opcodes 0 to 3 start a stream transfer with the data address, the request count and key bits 1:0. The direction output is 1 for opcodes 0 and 1, and the last flag equals opcode bit 0. The residual reported at done becomes the descriptor residual.
- R4: On completion the dependent word is written back to P+8, then {status, residual} to P+12. The status snapshot is taken before FLUSH is cleared, and FLUSH is clear afterwards. `statusWord` bits are: run 15, flush 13, wake 12, dead 11, active 10, branch-taken 8, device status 7:0.
- R5: The interrupt field raises a one-cycle `irqPulse` when it is 3, when it is 1 and `intrCond` is 1, or when it is 2 and `intrCond` is 0; field 0 never raises it.
- R6: The branch field uses the same encoding with `branchCond`. A taken branch loads the pointer from the dependent word with its low four bits cleared, and sets branch-taken. Otherwise the pointer advances by 16 and branch-taken is cleared.
- R7: Opcode 7 clears active, dead and flush, writes nothing back, and leaves the pointer unchanged.
- R8: The channel is killed in these cases: key 4 on any opcode other than 6 and 7; a stream opcode with a key above 3 or a zero data address; a word opcode with key 5 or 7; or an opcode above 7. A kill sets dead, clears active, pulses `irqPulse`, writes nothing back, starts no transfer and leaves the pointer unchanged.
- R9: Word opcodes (4 store, 5 load) use count bits 2:0. Bit 2 selects 4 bytes with the address aligned down to 4, bit 1 selects 2 bytes aligned down to 2, and otherwise 1 byte is used. A load places the bytes in the top of the dependent word and keeps its lower bits. A store writes the top bytes of the dependent word to the addressed byte lanes. Word opcodes always advance, whatever the branch field says.
- R10: While the wait field selects a true condition against `waitCond`, nothing is written back and the pointer does not move. The check repeats every cycle, and the descriptor completes once it stops holding.
- R11: Wake is cleared when a fetched descriptor is decoded. A `wakeIn` pulse sets wake and active, and restarts a stopped channel at the current pointer while `runIn` is high.
- R12: A rising `runIn` sets active and clears dead, and a falling `runIn` clears active and dead. `ptrLoad` takes effect only when neither run nor active is set, and it clears the low four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runIn | input | 1 | Channel run level |
| wakeIn | input | 1 | Wake pulse |
| flushIn | input | 1 | Sets the flush flag |
| ptrLoad | input | 1 | Load command pointer |
| ptrIn | input | 32 | New command pointer |
| devStat | input | 8 | Device status bits |
| waitCond | input | 1 | Wait condition result |
| intrCond | input | 1 | Interrupt condition result |
| branchCond | input | 1 | Branch condition result |
| memReq | output | 1 | Memory request, held until ack |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Word-aligned memory address |
| memWData | output | 32 | Memory write data |
| memStrb | output | 4 | Byte lane enables for writes |
| memAck | input | 1 | Memory acknowledge |
| memRData | input | 32 | Read data, valid with ack |
| xferReq | output | 1 | Stream transfer request, held until done |
| xferOut | output | 1 | 1 for memory-to-device |
| xferLast | output | 1 | Last segment flag |
| xferKey | output | 2 | Stream selector |
| xferAddr | output | 32 | Transfer data address |
| xferLen | output | 16 | Requested byte count |
| xferDone | input | 1 | Transfer complete |
| xferResid | input | 16 | Bytes left at completion |
| irqPulse | output | 1 | One-cycle interrupt |
| cmdPtr | output | 32 | Current command pointer |
| statusWord | output | 16 | Channel status |

## Verification
The bench targets the places where decode choices interact. One is a load or store whose branch field says always: a design that honoured it would jump to an arbitrary target. Another is a short load at an odd address, where a wrong alignment or lane shift corrupts the kept low bits of the dependent word. A third is a held wait condition: a design that writes back early would show a changed status word in memory while the channel still waits. The bench also checks that kills leave both memory and pointer untouched, that a stop does not advance, and that flush appears in the written status but is clear afterwards. It further checks that a pointer load is refused while run is high.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = 16;
  localparam int DEV_W      = 8;
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_SH    = $clog2(LANES);
  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = DESC_BYTES / LANES;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int DEP_OFS    = 2 * LANES;
  localparam int STAT_OFS   = 3 * LANES;

  localparam logic [3:0] OP_STORE = 4'd4;
  localparam logic [3:0] OP_LOAD  = 4'd5;
  localparam logic [3:0] OP_NOP   = 4'd6;
  localparam logic [3:0] OP_STOP  = 4'd7;

  typedef enum logic [1:0] {MS_FETCH, MS_DEP, MS_STAT, MS_DATA} memSel_t;

  typedef struct packed {
    logic capture;
    logic clrWake;
    logic kill;
    logic stop;
    logic capResid;
    logic capLoad;
    logic clrFlush;
    logic advance;
    logic branch;
  } seqStrobe_t;

  function automatic logic condHit(input logic [1:0] sel, input logic cond);
    return (sel == 2'd3) || (sel == 2'd1 && cond) || (sel == 2'd2 && !cond);
  endfunction
endpackage

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runGo,
  input  logic             activeFlag,
  input  logic [3:0]       opcode,
  input  logic [2:0]       key,
  input  logic             addrZero,
  input  logic [1:0]       waitSel,
  input  logic [1:0]       intrSel,
  input  logic [1:0]       brSel,
  input  logic             waitCond,
  input  logic             intrCond,
  input  logic             branchCond,
  input  logic             memAck,
  input  logic             xferDone,
  output logic             memReq,
  output logic             memWe,
  output logic             xferReq,
  output logic             irqPulse,
  output memSel_t          memSel,
  output logic [IDX_W-1:0] wordIdx,
  output seqStrobe_t       strobe
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_WORD, S_WAITC, S_WB_DEP, S_WB_STAT, S_FINISH
  } seqState_t;

  seqState_t        state, nextState;
  logic [IDX_W-1:0] idxNext;
  logic             wordOp, wordOpNext;
  logic             waitHit, intrHit, brHit;
  logic             badStream, badWord;

  assign waitHit   = condHit(waitSel, waitCond);
  assign intrHit   = condHit(intrSel, intrCond);
  assign brHit     = condHit(brSel, branchCond);
  assign badStream = (key > 3'd3) || addrZero;
  assign badWord   = (key == 3'd4) || (key == 3'd5) || (key == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      wordOp  <= 1'b0;
    end else begin
      state   <= nextState;
      wordIdx <= idxNext;
      wordOp  <= wordOpNext;
    end
  end

  always_comb begin
    nextState  = state;
    idxNext    = wordIdx;
    wordOpNext = wordOp;
    strobe     = '0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    memSel     = MS_FETCH;
    xferReq    = 1'b0;
    irqPulse   = 1'b0;
    case (state)
      S_IDLE: begin
        idxNext = '0;
        if (runGo) nextState = S_FETCH;
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capture = 1'b1;
          if (wordIdx == IDX_W'(DESC_WORDS - 1)) nextState = S_DECODE;
          else idxNext = wordIdx + 1'b1;
        end
      end
      S_DECODE: begin
        strobe.clrWake = 1'b1;
        wordOpNext     = 1'b0;
        if (opcode == OP_STOP) begin
          strobe.stop = 1'b1;
          nextState   = S_IDLE;
        end else if (opcode == OP_NOP) begin
          nextState = S_WAITC;
        end else if (opcode < OP_STORE) begin
          if (badStream) begin
            strobe.kill = 1'b1;
            irqPulse    = 1'b1;
            nextState   = S_IDLE;
          end else begin
            nextState = S_XFER;
          end
        end else if (opcode == OP_STORE || opcode == OP_LOAD) begin
          if (badWord) begin
            strobe.kill = 1'b1;
            irqPulse    = 1'b1;
            nextState   = S_IDLE;
          end else begin
            wordOpNext = 1'b1;
            nextState  = S_WORD;
          end
        end else begin
          strobe.kill = 1'b1;
          irqPulse    = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_XFER: begin
        xferReq = 1'b1;
        if (xferDone) begin
          strobe.capResid = 1'b1;
          nextState       = S_WAITC;
        end
      end
      S_WORD: begin
        memReq = 1'b1;
        memSel = MS_DATA;
        memWe  = (opcode == OP_STORE);
        if (memAck) begin
          strobe.capLoad = (opcode == OP_LOAD);
          nextState      = S_WAITC;
        end
      end
      S_WAITC: begin
        if (!activeFlag) nextState = S_IDLE;
        else if (!waitHit) nextState = S_WB_DEP;
      end
      S_WB_DEP: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        memSel = MS_DEP;
        if (memAck) nextState = S_WB_STAT;
      end
      S_WB_STAT: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        memSel = MS_STAT;
        if (memAck) nextState = S_FINISH;
      end
      S_FINISH: begin
        strobe.clrFlush = 1'b1;
        irqPulse        = intrHit;
        if (!wordOp && brHit) strobe.branch = 1'b1;
        else strobe.advance = 1'b1;
        idxNext   = '0;
        nextState = runGo ? S_FETCH : S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/dseq_datapath.sv
module dseq_datapath
  import dseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  memSel_t           memSel,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              runIn,
  input  logic              wakeIn,
  input  logic              flushIn,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic [DEV_W-1:0]  devStat,
  input  logic [DATA_W-1:0] memRData,
  input  logic [HALF_W-1:0] xferResid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [LANES-1:0]  memStrb,
  output logic [3:0]        opcode,
  output logic [2:0]        key,
  output logic [1:0]        waitSel,
  output logic [1:0]        intrSel,
  output logic [1:0]        brSel,
  output logic              addrZero,
  output logic              runGo,
  output logic              activeFlag,
  output logic              xferOut,
  output logic              xferLast,
  output logic [1:0]        xferKey,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [HALF_W-1:0] xferLen,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic [HALF_W-1:0] statusWord
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(DESC_BYTES - 1);

  logic [HALF_W-1:0] reqCount, resid;
  logic [ADDR_W-1:0] dataAddr, wordAddr;
  logic [DATA_W-1:0] cmdDep, loadVal, storeVal;
  logic              flushF, wakeF, deadF, activeF, btF, runPrev;
  logic              size4, size2;
  logic [1:0]        ofs;
  logic [LANES-1:0]  dataStrb;
  logic [HALF_W-1:0] loadHalf;
  logic [7:0]        loadByte;

  // word access sizing from the low count bits
  assign size4    = reqCount[2];
  assign size2    = !reqCount[2] && reqCount[1];
  assign wordAddr = size4 ? {dataAddr[ADDR_W-1:2], 2'b00}
                  : size2 ? {dataAddr[ADDR_W-1:1], 1'b0} : dataAddr;
  assign ofs      = wordAddr[1:0];
  assign loadHalf = HALF_W'(memRData >> {ofs, 3'b000});
  assign loadByte = 8'(memRData >> {ofs, 3'b000});
  assign loadVal  = size4 ? memRData
                  : size2 ? {loadHalf, cmdDep[HALF_W-1:0]}
                          : {loadByte, cmdDep[DATA_W-9:0]};
  assign storeVal = size4 ? cmdDep
                  : size2 ? {(LANES/2){cmdDep[DATA_W-1:HALF_W]}}
                          : {LANES{cmdDep[DATA_W-1:DATA_W-8]}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] LANE_ID = 2'(l);
    assign dataStrb[l] = size4 || (size2 && (LANE_ID[1] == ofs[1])) || (LANE_ID == ofs);
  end

  always_comb begin
    memStrb  = '1;
    memWData = cmdDep;
    case (memSel)
      MS_FETCH: memAddr = cmdPtr + (ADDR_W'(wordIdx) << LANE_SH);
      MS_DEP:   memAddr = cmdPtr + ADDR_W'(DEP_OFS);
      MS_STAT: begin
        memAddr  = cmdPtr + ADDR_W'(STAT_OFS);
        memWData = {statusWord, resid};
      end
      default: begin
        memAddr  = {wordAddr[ADDR_W-1:LANE_SH], {LANE_SH{1'b0}}};
        memWData = storeVal;
        memStrb  = dataStrb;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCount <= '0; opcode <= '0; key <= '0;
      intrSel <= '0; brSel <= '0; waitSel <= '0;
      dataAddr <= '0; cmdDep <= '0; resid <= '0;
      cmdPtr <= '0; flushF <= 1'b0; wakeF <= 1'b0; deadF <= 1'b0;
      activeF <= 1'b0; btF <= 1'b0; runPrev <= 1'b0;
    end else begin
      runPrev <= runIn;
      if (strobe.capture) begin
        case (wordIdx)
          2'd0: begin
            reqCount <= memRData[15:0];
            opcode   <= memRData[31:28];
            key      <= memRData[26:24];
            intrSel  <= memRData[21:20];
            brSel    <= memRData[19:18];
            waitSel  <= memRData[17:16];
          end
          2'd1:    dataAddr <= memRData;
          2'd2:    cmdDep   <= memRData;
          default: resid    <= memRData[HALF_W-1:0];
        endcase
      end
      if (strobe.capResid) resid <= xferResid;
      if (strobe.capLoad) cmdDep <= loadVal;
      if (strobe.clrWake) wakeF <= 1'b0;
      if (strobe.kill) begin
        deadF   <= 1'b1;
        activeF <= 1'b0;
      end
      if (strobe.stop) begin
        activeF <= 1'b0;
        deadF   <= 1'b0;
        flushF  <= 1'b0;
      end
      if (strobe.clrFlush) flushF <= 1'b0;
      if (strobe.advance) begin
        btF    <= 1'b0;
        cmdPtr <= cmdPtr + ADDR_W'(DESC_BYTES);
      end
      if (strobe.branch) begin
        btF    <= 1'b1;
        cmdPtr <= cmdDep & ALIGN_MASK;
      end
      if (flushIn) flushF <= 1'b1;
      if (wakeIn) begin
        wakeF   <= 1'b1;
        activeF <= 1'b1;
      end
      if (runIn && !runPrev) begin
        activeF <= 1'b1;
        deadF   <= 1'b0;
      end
      if (!runIn && runPrev) begin
        activeF <= 1'b0;
        deadF   <= 1'b0;
      end
      if (ptrLoad && !runIn && !activeF) cmdPtr <= ptrIn & ALIGN_MASK;
    end
  end

  assign statusWord = {runIn, 1'b0, flushF, wakeF, deadF, activeF, 1'b0, btF, devStat};
  assign runGo      = runIn && activeF;
  assign activeFlag = activeF;
  assign addrZero   = (dataAddr == '0);
  assign xferOut    = !opcode[1];
  assign xferLast   = opcode[0];
  assign xferKey    = key[1:0];
  assign xferAddr   = dataAddr;
  assign xferLen    = reqCount;
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runIn,
  input  logic        wakeIn,
  input  logic        flushIn,
  input  logic        ptrLoad,
  input  logic [31:0] ptrIn,
  input  logic [7:0]  devStat,
  input  logic        waitCond,
  input  logic        intrCond,
  input  logic        branchCond,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  output logic [3:0]  memStrb,
  input  logic        memAck,
  input  logic [31:0] memRData,
  output logic        xferReq,
  output logic        xferOut,
  output logic        xferLast,
  output logic [1:0]  xferKey,
  output logic [31:0] xferAddr,
  output logic [15:0] xferLen,
  input  logic        xferDone,
  input  logic [15:0] xferResid,
  output logic        irqPulse,
  output logic [31:0] cmdPtr,
  output logic [15:0] statusWord
);
  seqStrobe_t       strobe;
  memSel_t          memSel;
  logic [IDX_W-1:0] wordIdx;
  logic [3:0]       opcode;
  logic [2:0]       key;
  logic [1:0]       waitSel, intrSel, brSel;
  logic             addrZero, runGo, activeFlag;

  dseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runGo(runGo), .activeFlag(activeFlag),
    .opcode(opcode), .key(key), .addrZero(addrZero),
    .waitSel(waitSel), .intrSel(intrSel), .brSel(brSel),
    .waitCond(waitCond), .intrCond(intrCond), .branchCond(branchCond),
    .memAck(memAck), .xferDone(xferDone),
    .memReq(memReq), .memWe(memWe), .xferReq(xferReq), .irqPulse(irqPulse),
    .memSel(memSel), .wordIdx(wordIdx), .strobe(strobe)
  );

  dseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memSel(memSel), .wordIdx(wordIdx),
    .runIn(runIn), .wakeIn(wakeIn), .flushIn(flushIn), .ptrLoad(ptrLoad),
    .ptrIn(ptrIn), .devStat(devStat), .memRData(memRData), .xferResid(xferResid),
    .memAddr(memAddr), .memWData(memWData), .memStrb(memStrb),
    .opcode(opcode), .key(key), .waitSel(waitSel), .intrSel(intrSel), .brSel(brSel),
    .addrZero(addrZero), .runGo(runGo), .activeFlag(activeFlag),
    .xferOut(xferOut), .xferLast(xferLast), .xferKey(xferKey),
    .xferAddr(xferAddr), .xferLen(xferLen), .cmdPtr(cmdPtr), .statusWord(statusWord)
  );
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] memWData,
  input logic        xferReq,
  input logic        xferDone,
  input logic        irqPulse,
  input logic [31:0] cmdPtr,
  input logic [15:0] statusWord
);
  AST_ONE_PORT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && xferReq)); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWData))); // R2

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferDone) |=> xferReq); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R5

  AST_DEAD_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[11]) |-> !statusWord[10]); // R8

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    cmdPtr[3:0] == 4'd0); // R12
endmodule

bind dseq_top dseq_checker u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .memWData(memWData), .xferReq(xferReq), .xferDone(xferDone), .irqPulse(irqPulse),
  .cmdPtr(cmdPtr), .statusWord(statusWord)
);

// File: tb/sim_dseq_top.sv
module sim_dseq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runIn = 1'b0, wakeIn = 1'b0, flushIn = 1'b0, ptrLoad = 1'b0;
  logic [31:0] ptrIn = '0;
  logic [7:0]  devStat = 8'hA5;
  logic        waitCond = 1'b0, intrCond = 1'b0, branchCond = 1'b0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWData, memRData = '0;
  logic [3:0]  memStrb;
  logic        xferReq, xferOut, xferLast, xferDone = 1'b0;
  logic [1:0]  xferKey;
  logic [31:0] xferAddr;
  logic [15:0] xferLen, xferResid = '0;
  logic        irqPulse;
  logic [31:0] cmdPtr;
  logic [15:0] statusWord;

  int checks = 0, fails = 0, irqCount = 0, xferCount = 0, cyc = 0;
  logic [31:0] mem [128];
  logic [15:0] devResid = 16'd5;
  logic [31:0] seenAddr;
  logic [15:0] seenLen;
  logic        seenOut, seenLast;
  logic [1:0]  seenKey;

  always #5 clk = ~clk;

  dseq_top u0 (.*);

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        for (int l = 0; l < 4; l++)
          if (memStrb[l]) mem[memAddr[8:2]][8*l +: 8] <= memWData[8*l +: 8];
      end else begin
        memRData <= mem[memAddr[8:2]];
      end
    end
  end

  always @(posedge clk) begin
    xferDone <= 1'b0;
    if (xferReq && !xferDone) begin
      xferDone  <= 1'b1;
      xferResid <= devResid;
      seenAddr  <= xferAddr; seenLen <= xferLen; seenOut <= xferOut;
      seenLast  <= xferLast; seenKey <= xferKey;
      xferCount <= xferCount + 1;
    end
    if (irqPulse) irqCount <= irqCount + 1;
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCmd(input logic [3:0] op, input logic [2:0] k,
                                        input logic [1:0] ir, input logic [1:0] br,
                                        input logic [1:0] wt);
    return {op, 1'b0, k, 2'b00, ir, br, wt};
  endfunction

  task automatic putDesc(input int a, input logic [15:0] cnt, input logic [15:0] cmd,
                         input logic [31:0] dAddr, input logic [31:0] dep,
                         input logic [15:0] res);
    mem[a/4]     = {cmd, cnt};
    mem[a/4 + 1] = dAddr;
    mem[a/4 + 2] = dep;
    mem[a/4 + 3] = {16'h0000, res};
  endtask

  task automatic waitIdle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (statusWord[10] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk("channel completion", 32'd0, 32'd1);
  endtask

  task automatic launch(input logic [31:0] p);
    runIn = 1'b0;
    @(negedge clk);
    ptrLoad = 1'b1; ptrIn = p;
    @(negedge clk);
    ptrLoad = 1'b0;
    runIn = 1'b1;
  endtask

  task automatic tReset();
    chk("R1 pointer", cmdPtr, 32'h0);
    chk("R1 status", {16'h0, statusWord}, 32'h0000_00A5);
    chk("R1 requests", {30'h0, memReq, xferReq}, 32'h0);
  endtask

  task automatic tStream();
    int irq0;
    putDesc(32'h40, 16'd20, mkCmd(4'd1, 3'd2, 2'd3, 2'd0, 2'd0), 32'h100, 32'h0, 16'h0);
    putDesc(32'h50, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    irq0 = irqCount;
    @(negedge clk); flushIn = 1'b1; @(negedge clk); flushIn = 1'b0;
    launch(32'h40);
    waitIdle();
    chk("R3 transfer address", seenAddr, 32'h100);
    chk("R3 transfer length/dir/last/key", {seenLen, 11'h0, seenOut, seenLast, 1'b0, seenKey},
        {16'd20, 11'h0, 1'b1, 1'b1, 1'b0, 2'd2});
    chk("R4 status and residual written", mem[32'h4C/4], 32'hA4A5_0005);
    chk("R5 interrupt always", irqCount - irq0, 32'd1);
    chk("R7 stop keeps pointer", cmdPtr, 32'h50);
    chk("R7 R4 status after stop", {16'h0, statusWord}, 32'h0000_80A5);
  endtask

  task automatic tBranch();
    int irq0;
    putDesc(32'h40, 16'd0, mkCmd(4'd6, 3'd0, 2'd0, 2'd1, 2'd0), 32'h0, 32'h200, 16'h0);
    putDesc(32'h50, 16'd0, mkCmd(4'd6, 3'd0, 2'd2, 2'd3, 2'd0), 32'h0, 32'h8F, 16'h0077);
    putDesc(32'h80, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    branchCond = 1'b0; intrCond = 1'b1;
    irq0 = irqCount;
    launch(32'h40);
    waitIdle();
    chk("R6 branch target aligned", cmdPtr, 32'h80);
    chk("R6 branch-taken flag", {16'h0, statusWord}, 32'h0000_81A5);
    chk("R6 advance cleared flag in writeback", mem[32'h5C/4], 32'h84A5_0077);
    chk("R5 if-clear with true condition", irqCount - irq0, 32'd0);
    intrCond = 1'b0;
  endtask

  task automatic tLoad();
    int irq0;
    mem[32'h100/4] = 32'hDEAD_BEEF;
    putDesc(32'h40, 16'd2, mkCmd(4'd5, 3'd6, 2'd1, 2'd3, 2'd0), 32'h103, 32'h1122_3344, 16'h0);
    putDesc(32'h50, 16'd1, mkCmd(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 32'h101, 32'h00AA_BBCC, 16'h0);
    putDesc(32'h60, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    intrCond = 1'b1;
    irq0 = irqCount;
    launch(32'h40);
    waitIdle();
    chk("R9 two-byte load", mem[32'h48/4], 32'hDEAD_3344);
    chk("R9 one-byte load", mem[32'h58/4], 32'hBEAA_BBCC);
    chk("R9 word op never branches", cmdPtr, 32'h60);
    chk("R5 if-set with true condition", irqCount - irq0, 32'd1);
    intrCond = 1'b0;
  endtask

  task automatic tStore();
    mem[32'h108/4] = 32'h1111_1111;
    mem[32'h10C/4] = 32'h0;
    mem[32'h110/4] = 32'h0;
    putDesc(32'h40, 16'd1, mkCmd(4'd4, 3'd0, 2'd0, 2'd0, 2'd0), 32'h109, 32'hAB00_0000, 16'h0);
    putDesc(32'h50, 16'd6, mkCmd(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 32'h10E, 32'hCAFE_F00D, 16'h0);
    putDesc(32'h60, 16'd2, mkCmd(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 32'h113, 32'h5566_7788, 16'h0);
    putDesc(32'h70, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    launch(32'h40);
    waitIdle();
    chk("R9 one-byte store lane", mem[32'h108/4], 32'h1111_AB11);
    chk("R9 four-byte store aligned", mem[32'h10C/4], 32'hCAFE_F00D);
    chk("R9 two-byte store upper half", mem[32'h110/4], 32'h5566_0000);
    chk("R9 store advances", cmdPtr, 32'h70);
  endtask

  task automatic tKill();
    int irq0, x0;
    putDesc(32'h40, 16'd8, mkCmd(4'd0, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    irq0 = irqCount; x0 = xferCount;
    launch(32'h40);
    waitIdle();
    chk("R8 zero address kills", {16'h0, statusWord}, 32'h0000_88A5);
    chk("R8 kill interrupt, no transfer", {irqCount - irq0, xferCount - x0}, {32'd1, 32'd0});
    chk("R8 no writeback on kill", mem[32'h4C/4], 32'h0);
    @(negedge clk); ptrLoad = 1'b1; ptrIn = 32'h200;
    @(negedge clk); ptrLoad = 1'b0;
    @(negedge clk);
    chk("R12 pointer load refused while run", cmdPtr, 32'h40);
    putDesc(32'h40, 16'd4, mkCmd(4'd2, 3'd5, 2'd0, 2'd0, 2'd0), 32'h100, 32'h0, 16'h0);
    launch(32'h40);
    waitIdle();
    chk("R8 stream key above 3", {xferCount - x0, 16'h0, statusWord}, {32'd0, 32'h0000_88A5});
    putDesc(32'h40, 16'd4, mkCmd(4'd5, 3'd4, 2'd0, 2'd0, 2'd0), 32'h100, 32'h0, 16'h0);
    launch(32'h40);
    waitIdle();
    chk("R8 key 4 on load", {cmdPtr, 16'h0, statusWord}, {32'h40, 32'h0000_88A5});
    runIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 run fall clears dead", {16'h0, statusWord}, 32'h0000_00A5);
    ptrLoad = 1'b1; ptrIn = 32'h4F;
    @(negedge clk); ptrLoad = 1'b0;
    @(negedge clk);
    chk("R12 pointer load aligned", cmdPtr, 32'h40);
  endtask

  task automatic tWait();
    putDesc(32'h40, 16'd0, mkCmd(4'd6, 3'd0, 2'd0, 2'd0, 2'd1), 32'h0, 32'h0, 16'h1234);
    putDesc(32'h50, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    waitCond = 1'b1;
    launch(32'h40);
    repeat (30) @(negedge clk);
    chk("R10 held wait blocks writeback", mem[32'h4C/4], 32'h0000_1234);
    chk("R10 held wait keeps pointer and active", {cmdPtr, 16'h0, statusWord},
        {32'h40, 32'h0000_84A5});
    waitCond = 1'b0;
    waitIdle();
    chk("R10 resumes after wait drops", mem[32'h4C/4], 32'h84A5_1234);
    chk("R10 pointer after resume", cmdPtr, 32'h50);
  endtask

  task automatic tWake();
    putDesc(32'h50, 16'd0, mkCmd(4'd6, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    putDesc(32'h60, 16'd0, mkCmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0, 16'h0);
    @(negedge clk); wakeIn = 1'b1;
    @(negedge clk); wakeIn = 1'b0;
    waitIdle();
    chk("R11 wake cleared at decode", mem[32'h5C/4], 32'h84A5_0000);
    chk("R11 wake restarts at pointer", cmdPtr, 32'h60);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStream();
    tBranch();
    tLoad();
    tStore();
    tKill();
    tWait();
    tWake();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule